// File: doc/BRIEF.md
# Control Endpoint Buffer Status Tracker

This block keeps the buffer status flags of a USB device controller. It has a full flag for every realized IN endpoint buffer. For the control OUT buffer it has a pending-SETUP flag, a held-packet flag and a packet-overwritten flag. Firmware reaches the block through a command port: an opcode strobe with an endpoint index. The packet engine reports events as strobes: SETUP received, OUT packet received, IN token and IN data sent.

A Validate command marks an IN buffer ready to transmit. The buffer stays full until the engine reports that its data went out. An IN token receives data only when the addressed buffer is full. The control IN buffer has two extra rules:

- A Validate for it is refused while the control OUT side holds an unread SETUP or an overwritten packet.
- An arriving SETUP cancels a validated control IN buffer.

A Clear Buffer command returns a status byte that carries the overwritten flag. A separate select/clear command clears that flag.

Top module: `ep_buf_tracker`

## Requirements
- R1: A synchronous active-high `rst` clears every IN full flag, `setupPending`, `overwritten`, the held-packet state and `rdValid`.
- R2: A Validate command (opcode 0xFA, no data) for a realized endpoint sets that endpoint's bit of `inFull` in the next cycle. For endpoint 0 this applies only when R5 does not refuse it.
- R3: `inHasData` is high in the same cycle as `inTok` exactly when `inTokEp` is realized and that endpoint's full flag is set. An IN token by itself leaves the full flag unchanged.
- R4: `inSent` for a realized endpoint clears that endpoint's full flag in the next cycle. If a Validate for the same endpoint arrives in the same cycle, the set wins.
- R5: A Validate for endpoint 0 is ignored while `setupPending` or `overwritten` is 1.
- R6: `setupRx` clears `inFull[0]` in the next cycle. This takes priority over a Validate for endpoint 0 in the same cycle.
- R7: `setupRx` sets `setupPending`. A Clear Buffer command (opcode 0xF2) for endpoint 0 clears it. When both arrive in the same cycle, the set wins.
- R8: The control OUT buffer counts as holding a packet after `outRx` or `setupRx`, until a Clear Buffer for endpoint 0. A `setupRx` that arrives while a packet is held sets `overwritten`.
- R9: A select/clear command (opcode 0x40) for endpoint 0 clears `overwritten`. A simultaneous R8 set wins.
- R10: A Clear Buffer for a realized endpoint pulses `rdValid` for one cycle on the next cycle. `rdStatus` bit 0 holds the value `overwritten` had when the command was issued for endpoint 0, and 0 for any other endpoint. Bits 7:1 are 0.
- R11: Commands, `inSent` and `inTok` whose endpoint index is NUM_EP or above have no effect on any flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 8 | Command opcode |
| cmdEp | input | EP_IDX_W | Command endpoint index |
| setupRx | input | 1 | SETUP packet received on endpoint 0 |
| outRx | input | 1 | OUT data packet received on endpoint 0 |
| inTok | input | 1 | IN token arrived |
| inTokEp | input | EP_IDX_W | Endpoint of the IN token |
| inSent | input | 1 | IN buffer contents transmitted |
| inSentEp | input | EP_IDX_W | Endpoint whose data was sent |
| inHasData | output | 1 | IN token can be answered with data |
| inFull | output | NUM_EP | IN buffer full flags |
| setupPending | output | 1 | Unread SETUP in control OUT buffer |
| overwritten | output | 1 | Control OUT packet overwritten by a SETUP |
| rdValid | output | 1 | Status byte valid |
| rdStatus | output | 8 | Clear Buffer status byte |

## Verification
The assertions check on every cycle the flag transitions that a single strobe causes:
- a Validate sets an ordinary full flag;
- a send clears it;
- SETUP cancels the control IN buffer and raises the pending flag;
- a refused control Validate leaves the flag low;
- the select/clear command drops the overwritten flag;
- the reserved status bits stay zero.

Only the bench scenarios show the ordering effects:
- that the overwritten flag needs an earlier unread packet;
- that the status byte reports the flag as it was before the command;
- the set-wins outcomes of same-cycle collisions;
- that out-of-range endpoint indices leave everything untouched.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  localparam logic [7:0] OP_VALIDATE = 8'hFA;
  localparam logic [7:0] OP_CLR_BUF  = 8'hF2;
  localparam logic [7:0] OP_SEL_CLR  = 8'h40;

  typedef struct packed {
    logic setupEv;
    logic outEv;
    logic valid0;
    logic clrBuf0;
    logic clrBufOther;
    logic selClr0;
  } ebt_strobe_t;
endpackage

// File: rtl/ebt_ctrl.sv
module ebt_ctrl
  import ebt_pkg::*;
#(
  parameter int NUM_EP   = 4,
  parameter int EP_IDX_W = 4
) (
  input  logic                cmdValid,
  input  logic [7:0]          cmdOp,
  input  logic [EP_IDX_W-1:0] cmdEp,
  input  logic                setupRx,
  input  logic                outRx,
  input  logic                inTok,
  input  logic [EP_IDX_W-1:0] inTokEp,
  input  logic                inSent,
  input  logic [EP_IDX_W-1:0] inSentEp,
  output ebt_strobe_t         strb,
  output logic [NUM_EP-1:0]   validVec,
  output logic [NUM_EP-1:0]   sentVec,
  output logic [NUM_EP-1:0]   tokVec
);
  localparam logic [EP_IDX_W:0] EP_LIMIT = (EP_IDX_W+1)'(NUM_EP);

  logic cmdOk;
  logic cmdIsZero;

  // Realized-endpoint filter (R11): indices at or above NUM_EP never decode.
  assign cmdOk     = cmdValid && ({1'b0, cmdEp} < EP_LIMIT);
  assign cmdIsZero = (cmdEp == '0);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_dec
    assign validVec[g] = cmdOk && (cmdOp == OP_VALIDATE) && (cmdEp == EP_IDX_W'(g));
    assign sentVec[g]  = inSent && (inSentEp == EP_IDX_W'(g));
    assign tokVec[g]   = inTok && (inTokEp == EP_IDX_W'(g));
  end

  always_comb begin
    strb.setupEv     = setupRx;
    strb.outEv       = outRx;
    strb.valid0      = validVec[0];
    strb.clrBuf0     = cmdOk && (cmdOp == OP_CLR_BUF) && cmdIsZero;
    strb.clrBufOther = cmdOk && (cmdOp == OP_CLR_BUF) && !cmdIsZero;
    strb.selClr0     = cmdOk && (cmdOp == OP_SEL_CLR) && cmdIsZero;
  end
endmodule

// File: rtl/ebt_dpath.sv
module ebt_dpath
  import ebt_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ebt_strobe_t       strb,
  input  logic [NUM_EP-1:0] validVec,
  input  logic [NUM_EP-1:0] sentVec,
  input  logic [NUM_EP-1:0] tokVec,
  output logic              inHasData,
  output logic [NUM_EP-1:0] inFull,
  output logic              setupPending,
  output logic              overwritten,
  output logic              rdValid,
  output logic [7:0]        rdStatus
);
  logic outHeld;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_buf
    logic fullQ;
    if (g == 0) begin : g_ctl
      always_ff @(posedge clk) begin
        if (rst)                                                fullQ <= 1'b0;
        else if (strb.setupEv)                                  fullQ <= 1'b0;
        else if (validVec[0] && !setupPending && !overwritten)  fullQ <= 1'b1;
        else if (sentVec[0])                                    fullQ <= 1'b0;
      end
      // R6: SETUP cancels the control IN buffer
      a_r6_setup_cancels: assert property (@(posedge clk) disable iff (rst)
        strb.setupEv |=> !inFull[0]);
      // R5: refused validate leaves the flag low
      a_r5_refuse: assert property (@(posedge clk) disable iff (rst)
        (validVec[0] && (setupPending || overwritten) && !inFull[0]) |=> !inFull[0]);
    end else begin : g_std
      always_ff @(posedge clk) begin
        if (rst)              fullQ <= 1'b0;
        else if (validVec[g]) fullQ <= 1'b1;
        else if (sentVec[g])  fullQ <= 1'b0;
      end
      // R2: validate sets an ordinary IN buffer
      a_r2_validate_sets: assert property (@(posedge clk) disable iff (rst)
        validVec[g] |=> inFull[g]);
      // R4: send clears when no validate competes
      a_r4_sent_clears: assert property (@(posedge clk) disable iff (rst)
        (sentVec[g] && !validVec[g]) |=> !inFull[g]);
    end
    assign inFull[g] = fullQ;
  end

  assign inHasData = |(tokVec & inFull);

  always_ff @(posedge clk) begin
    if (rst) begin
      setupPending <= 1'b0;
      outHeld      <= 1'b0;
      overwritten  <= 1'b0;
      rdValid      <= 1'b0;
      rdStatus     <= 8'h00;
    end else begin
      if (strb.setupEv)      setupPending <= 1'b1;
      else if (strb.clrBuf0) setupPending <= 1'b0;

      if (strb.setupEv || strb.outEv) outHeld <= 1'b1;
      else if (strb.clrBuf0)          outHeld <= 1'b0;

      if (strb.setupEv && outHeld) overwritten <= 1'b1;
      else if (strb.selClr0)       overwritten <= 1'b0;

      rdValid  <= strb.clrBuf0 || strb.clrBufOther;
      rdStatus <= {7'b0, strb.clrBuf0 ? overwritten : 1'b0};
    end
  end

  // R7: SETUP raises the pending flag
  a_r7_setup_pending: assert property (@(posedge clk) disable iff (rst)
    strb.setupEv |=> setupPending);
  // R9: select/clear drops the overwritten flag when no SETUP competes
  a_r9_selclr: assert property (@(posedge clk) disable iff (rst)
    (strb.selClr0 && !strb.setupEv) |=> !overwritten);
  // R10: reserved status bits stay zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> (rdStatus[7:1] == 7'b0));
  // R1: reset clears the flags
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (inFull == '0 && !setupPending && !overwritten && !rdValid));
endmodule

// File: rtl/ep_buf_tracker.sv
module ep_buf_tracker
  import ebt_pkg::*;
#(
  parameter int NUM_EP   = 4,
  parameter int EP_IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdValid,
  input  logic [7:0]          cmdOp,
  input  logic [EP_IDX_W-1:0] cmdEp,
  input  logic                setupRx,
  input  logic                outRx,
  input  logic                inTok,
  input  logic [EP_IDX_W-1:0] inTokEp,
  input  logic                inSent,
  input  logic [EP_IDX_W-1:0] inSentEp,
  output logic                inHasData,
  output logic [NUM_EP-1:0]   inFull,
  output logic                setupPending,
  output logic                overwritten,
  output logic                rdValid,
  output logic [7:0]          rdStatus
);
  ebt_strobe_t       strb;
  logic [NUM_EP-1:0] validVec;
  logic [NUM_EP-1:0] sentVec;
  logic [NUM_EP-1:0] tokVec;

  ebt_ctrl #(.NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W)) u_ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdEp(cmdEp),
    .setupRx(setupRx), .outRx(outRx),
    .inTok(inTok), .inTokEp(inTokEp),
    .inSent(inSent), .inSentEp(inSentEp),
    .strb(strb), .validVec(validVec), .sentVec(sentVec), .tokVec(tokVec)
  );

  ebt_dpath #(.NUM_EP(NUM_EP)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb),
    .validVec(validVec), .sentVec(sentVec), .tokVec(tokVec),
    .inHasData(inHasData), .inFull(inFull),
    .setupPending(setupPending), .overwritten(overwritten),
    .rdValid(rdValid), .rdStatus(rdStatus)
  );
endmodule

// File: tb/ep_buf_tracker_tb.sv
module ep_buf_tracker_tb;
  localparam int NUM_EP   = 4;
  localparam int EP_IDX_W = 4;
  localparam logic [7:0] VAL = 8'hFA;
  localparam logic [7:0] CLR = 8'hF2;
  localparam logic [7:0] SEL = 8'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [7:0] cmdOp = 8'h00;
  logic [EP_IDX_W-1:0] cmdEp = '0;
  logic setupRx = 1'b0, outRx = 1'b0, inTok = 1'b0, inSent = 1'b0;
  logic [EP_IDX_W-1:0] inTokEp = '0, inSentEp = '0;
  logic inHasData, setupPending, overwritten, rdValid;
  logic [NUM_EP-1:0] inFull;
  logic [7:0] rdStatus;

  always #4 clk = ~clk;

  ep_buf_tracker #(.NUM_EP(NUM_EP), .EP_IDX_W(EP_IDX_W)) u_dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdEp(cmdEp),
    .setupRx(setupRx), .outRx(outRx), .inTok(inTok), .inTokEp(inTokEp),
    .inSent(inSent), .inSentEp(inSentEp), .inHasData(inHasData),
    .inFull(inFull), .setupPending(setupPending), .overwritten(overwritten),
    .rdValid(rdValid), .rdStatus(rdStatus)
  );

  typedef struct {
    string             tag;
    logic [NUM_EP-1:0] full;
    logic              sp;
    logic              po;
    logic              rdv;
    logic [7:0]        rds;
    int                due;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [NUM_EP-1:0] mFull = '0;
  logic mSp = 1'b0, mPo = 1'b0, mHeld = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit realized(input logic [EP_IDX_W-1:0] e);
    return int'(e) < NUM_EP;
  endfunction

  // monitor: pop and compare items that are due
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      exp_t it;
      it = expQ.pop_front();
      checks++;
      if (inFull !== it.full || setupPending !== it.sp || overwritten !== it.po ||
          rdValid !== it.rdv || (it.rdv && rdStatus !== it.rds)) begin
        errors++;
        $display("FAIL %s: got full=%b sp=%b po=%b rdv=%b rds=%h exp full=%b sp=%b po=%b rdv=%b rds=%h",
                 it.tag, inFull, setupPending, overwritten, rdValid, rdStatus,
                 it.full, it.sp, it.po, it.rdv, it.rds);
      end
    end
  end

  task automatic step(input string tag, input bit cv, input logic [7:0] op,
                      input logic [EP_IDX_W-1:0] ep, input bit su, input bit orx,
                      input bit tk, input logic [EP_IDX_W-1:0] tkEp,
                      input bit sn, input logic [EP_IDX_W-1:0] snEp);
    exp_t it;
    logic [NUM_EP-1:0] nFull;
    logic nSp, nPo, nHeld, rdv;
    logic [7:0] rds;
    @(negedge clk);
    cmdValid = cv; cmdOp = op; cmdEp = ep; setupRx = su; outRx = orx;
    inTok = tk; inTokEp = tkEp; inSent = sn; inSentEp = snEp;
    #1;
    if (tk) begin
      bit e;
      e = realized(tkEp) && mFull[tkEp[1:0]];
      checks++;
      if (inHasData !== e) begin
        errors++;
        $display("FAIL R3 %s: inHasData got %b exp %b", tag, inHasData, e);
      end
    end
    nFull = mFull; nSp = mSp; nPo = mPo; nHeld = mHeld; rdv = 1'b0; rds = 8'h00;
    if (sn && realized(snEp)) nFull[snEp[1:0]] = 1'b0;
    if (cv && op == VAL && realized(ep))
      if (ep != 0 || (!mSp && !mPo)) nFull[ep[1:0]] = 1'b1;
    if (su) nFull[0] = 1'b0;
    if (cv && op == CLR && ep == 0) begin nSp = 1'b0; nHeld = 1'b0; end
    if (su || orx) nHeld = 1'b1;
    if (su) nSp = 1'b1;
    if (cv && op == SEL && ep == 0) nPo = 1'b0;
    if (su && mHeld) nPo = 1'b1;
    if (cv && op == CLR && realized(ep)) begin
      rdv = 1'b1;
      rds = (ep == 0) ? {7'b0, mPo} : 8'h00;
    end
    mFull = nFull; mSp = nSp; mPo = nPo; mHeld = nHeld;
    it.tag = tag; it.full = nFull; it.sp = nSp; it.po = nPo;
    it.rdv = rdv; it.rds = rds; it.due = cyc + 1;
    expQ.push_back(it);
  endtask

  task automatic idle();
    step("idle", 0, 8'h00, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (inFull !== '0 || setupPending !== 1'b0 || overwritten !== 1'b0 || rdValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got full=%b sp=%b po=%b rdv=%b exp all 0",
               inFull, setupPending, overwritten, rdValid);
    end
    step("R2 validate ep2",                1, VAL, 2, 0, 0, 0, 0, 0, 0);
    step("R3 token ep2 full",              0, 0,   0, 0, 0, 1, 2, 0, 0);
    step("R3 token ep1 empty",             0, 0,   0, 0, 0, 1, 1, 0, 0);
    step("R4 sent ep2",                    0, 0,   0, 0, 0, 0, 0, 1, 2);
    step("R3 token ep2 after send",        0, 0,   0, 0, 0, 1, 2, 0, 0);
    step("R2 validate ep0",                1, VAL, 0, 0, 0, 0, 0, 0, 0);
    step("R6 setup cancels ep0",           0, 0,   0, 1, 0, 0, 0, 0, 0);
    step("R5 validate ep0 refused pend",   1, VAL, 0, 0, 0, 0, 0, 0, 0);
    step("R10 clear buf ep0 po0",          1, CLR, 0, 0, 0, 0, 0, 0, 0);
    step("R8 out rx held",                 0, 0,   0, 0, 1, 0, 0, 0, 0);
    step("R8 setup overwrites",            0, 0,   0, 1, 0, 0, 0, 0, 0);
    step("R10 clear buf ep0 po1",          1, CLR, 0, 0, 0, 0, 0, 0, 0);
    step("R5 validate ep0 refused po",     1, VAL, 0, 0, 0, 0, 0, 0, 0);
    step("R9 select clear ep0",            1, SEL, 0, 0, 0, 0, 0, 0, 0);
    step("R2 validate ep0 accepted",       1, VAL, 0, 0, 0, 0, 0, 0, 0);
    step("R6 setup beats validate",        1, VAL, 0, 1, 0, 0, 0, 0, 0);
    step("R7 setup beats clear buf",       1, CLR, 0, 1, 0, 0, 0, 0, 0);
    step("R9 setup beats select clear",    1, SEL, 0, 1, 0, 0, 0, 0, 0);
    step("R11 validate ep5 ignored",       1, VAL, 5, 0, 0, 0, 0, 0, 0);
    step("R11 token ep9 sent ep7",         0, 0,   0, 0, 0, 1, 9, 1, 7);
    step("R11 clear buf ep12 ignored",     1, CLR, 12, 0, 0, 0, 0, 0, 0);
    step("R11 select clear ep6 ignored",   1, SEL, 6, 0, 0, 0, 0, 0, 0);
    step("R10 clear buf ep1",              1, CLR, 1, 0, 0, 0, 0, 0, 0);
    step("R2 validate ep1",                1, VAL, 1, 0, 0, 0, 0, 0, 0);
    step("R4 validate wins over sent ep1", 1, VAL, 1, 0, 0, 0, 0, 1, 1);
    step("R4 sent ep1",                    0, 0,   0, 0, 0, 0, 0, 1, 1);
    idle();
    idle();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule